// File: doc/BRIEF.md
# Zero-Penalty Instruction Cache with Write Buffer

This block sits between a core's instruction fetch stage and a flash program memory that answers in one cycle. Its purpose is to cut the number of flash reads without changing when any fetched word arrives. Every lookup returns its word exactly one cycle after the address is presented, whether the word comes from the cache array, the write buffer or flash. As a result, the core's cycle-level timing stays the same as it would be with no cache fitted.

A word that misses is read from flash and delivered to the core. On the cycle after that, the same word is parked in a single-entry write buffer, and it is not written into the array at that point. The buffered word moves into the array during a later cycle in which the array is not being read. Such cycles include a cycle with another miss, an idle cycle, a cycle in which the core's instruction queue still holds a valid instruction, and a buffer hit. The single-ported array is therefore never read and written in the same cycle. Lookups compare against the buffer, the word still arriving from flash, and every way of the array. Hit detection uses only registered state.

Capacity (128 bytes to 4 KB) and associativity (1, 2 or 4 ways) are parameters. The line is one 32-bit word. With more than one way, the victim is chosen by tree pseudo-LRU.

Top module: `zp_icache`

## Requirements
- R1: Every lookup (fetch_req high while iq_valid is low) produces fetch_valid high in the following cycle, and fetch_data carries the word at that address in that cycle. No lookup ever takes longer.
- R2: A lookup that hits nowhere drives flash_req high in the same cycle, with flash_addr equal to fetch_addr. The response in the next cycle is the flash_data word.
- R3: A missed word is captured into the write buffer in the cycle after the miss. A lookup of that address while the word sits in the buffer is served without any flash access.
- R4: A buffered word is written into the array only in a cycle with no array read. A new miss always provides such a cycle, so a buffered word survives a following miss even when array hits come right after that miss.
- R5: A lookup that hits in the array or the buffer leaves flash_req low and returns the correct word. The buffer takes priority over the array when both match.
- R6: A lookup in the cycle right after a miss, to the same address, hits the word still arriving from flash and does not read flash again.
- R7: While iq_valid is high, fetch_req is ignored. There is no flash access and no response in the next cycle, and nothing is filled.
- R8: Reset clears every valid bit, so the first lookup of any address after reset misses.
- R9: A fill goes to the lowest-numbered invalid way of its set. With all ways valid, the fill goes to the pseudo-LRU victim, and that victim is updated on every array hit and every fill. With 2 ways, one bit per set names the way that was not used most recently. With 4 ways, a 3-bit tree is used.
- R10: The set index is the low log2(sets) bits of the word address and the tag is the remaining upper bits. Addresses that differ only in tag bits occupy separate ways of one set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Core requests a word this cycle |
| iq_valid | input | 1 | Core instruction queue still holds a valid instruction; suppresses lookup |
| fetch_addr | input | AW | Word address of the fetch |
| fetch_valid | output | 1 | Response valid (cycle after a lookup) |
| fetch_data | output | 32 | Fetched instruction word |
| flash_req | output | 1 | Flash read strobe |
| flash_addr | output | AW | Flash word address |
| flash_data | input | 32 | Flash read data, valid the cycle after flash_req |

## Verification
A wrong valid bit or tag does not corrupt data silently. It shows up at the flash port as an unexpected flash_req or a missing one, in the very cycle of the lookup. A buffer word that is dropped or committed at the wrong moment shows up one or two lookups later, as a second flash read of an address that should have been resident. A broken pseudo-LRU state shows up as the wrong address being re-read from flash after an eviction. Corrupted array or buffer contents appear on fetch_data exactly one cycle after the lookup.

// File: rtl/icz_pkg.sv
package icz_pkg;

  typedef logic [1:0] way_t;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FLASH = 2'd1,
    SRC_ARRAY = 2'd2,
    SRC_BUF   = 2'd3
  } src_e;

  // Victim way from the per-set pseudo-LRU state.
  function automatic way_t plru_victim(input int ways, input logic [2:0] t);
    if (ways == 1) return 2'd0;
    if (ways == 2) return {1'b0, t[0]};
    return t[0] ? (t[2] ? 2'd3 : 2'd2) : (t[1] ? 2'd1 : 2'd0);
  endfunction

  // State after way w was used: every node points away from w.
  function automatic logic [2:0] plru_touch(input int ways, input logic [2:0] t,
                                            input way_t w);
    logic [2:0] n;
    n = t;
    if (ways == 2) begin
      n[0] = ~w[0];
    end else if (ways == 4) begin
      n[0] = ~w[1];
      if (!w[1]) n[1] = ~w[0];
      else       n[2] = ~w[0];
    end
    return n;
  endfunction

endpackage

// File: rtl/icz_tag_store.sv
module icz_tag_store
  import icz_pkg::*;
#(
  parameter int AW   = 16,
  parameter int WAYS = 2,
  parameter int SETS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  input  logic          touch_en,
  input  logic          fill_en,
  input  logic [AW-1:0] fill_addr,
  output logic          arr_hit,
  output way_t          hit_way,
  output way_t          fill_way
);

  localparam int IDXW = $clog2(SETS);
  localparam int TAGW = AW - IDXW;

  function automatic logic [IDXW-1:0] set_of(input logic [AW-1:0] a);
    return a[IDXW-1:0];
  endfunction

  function automatic logic [TAGW-1:0] tag_of(input logic [AW-1:0] a);
    return a[AW-1:IDXW];
  endfunction

  logic [IDXW-1:0] lk_idx, fl_idx;
  logic [TAGW-1:0] lk_tag, fl_tag;
  logic [WAYS-1:0] way_hit;
  logic [WAYS-1:0] fill_inv;
  logic [2:0]      plru_q [SETS];

  assign lk_idx = set_of(lk_addr);
  assign lk_tag = tag_of(lk_addr);
  assign fl_idx = set_of(fill_addr);
  assign fl_tag = tag_of(fill_addr);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0] vld;
    logic [TAGW-1:0] tag [SETS];

    assign way_hit[w]  = vld[lk_idx] && (tag[lk_idx] == lk_tag);
    assign fill_inv[w] = !vld[fl_idx];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else if (fill_en && fill_way == way_t'(w)) vld[fl_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == way_t'(w)) tag[fl_idx] <= fl_tag;
    end
  end

  assign arr_hit = |way_hit;

  always_comb begin
    hit_way = 2'd0;
    for (int w = 0; w < WAYS; w++) if (way_hit[w]) hit_way = way_t'(w);
  end

  always_comb begin
    fill_way = plru_victim(WAYS, plru_q[fl_idx]);
    for (int w = WAYS - 1; w >= 0; w--) if (fill_inv[w]) fill_way = way_t'(w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) plru_q[s] <= 3'd0;
    end else if (fill_en) begin
      plru_q[fl_idx] <= plru_touch(WAYS, plru_q[fl_idx], fill_way);
    end else if (touch_en) begin
      plru_q[lk_idx] <= plru_touch(WAYS, plru_q[lk_idx], hit_way);
    end
  end

  // R9
  one_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

endmodule

// File: rtl/icz_data_array.sv
module icz_data_array
  import icz_pkg::*;
#(
  parameter int WAYS = 2,
  parameter int SETS = 64,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  way_t                    rd_way,
  input  logic [$clog2(SETS)-1:0] rd_idx,
  input  logic                    wr_en,
  input  way_t                    wr_way,
  input  logic [$clog2(SETS)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data
);

  logic [WAYS-1:0][DW-1:0] way_word;
  logic [DW-1:0]           rd_sel;

  for (genvar w = 0; w < WAYS; w++) begin : g_mem
    logic [DW-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == way_t'(w)) mem[wr_idx] <= wr_data;
    end
    assign way_word[w] = mem[rd_idx];
  end

  always_comb begin
    rd_sel = '0;
    for (int w = 0; w < WAYS; w++) if (rd_way == way_t'(w)) rd_sel = way_word[w];
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= rd_sel;
  end

  // R4
  no_rw_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));

endmodule

// File: rtl/icz_wbuf.sv
module icz_wbuf #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss,
  input  logic [AW-1:0] miss_addr,
  input  logic [DW-1:0] flash_data,
  input  logic          port_free,
  output logic          pend_vld,
  output logic [AW-1:0] pend_addr,
  output logic          buf_vld,
  output logic [AW-1:0] buf_addr,
  output logic [DW-1:0] buf_data,
  output logic          commit
);

  assign commit = buf_vld && port_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld <= 1'b0;
      buf_vld  <= 1'b0;
    end else begin
      pend_vld <= miss;
      if (pend_vld)    buf_vld <= 1'b1;
      else if (commit) buf_vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (miss) pend_addr <= miss_addr;
    if (pend_vld) begin
      buf_addr <= pend_addr;
      buf_data <= flash_data;
    end
  end

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |=> buf_vld);

  // R4
  commit_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !pend_vld) |=> !buf_vld);

endmodule

// File: rtl/zp_icache.sv
module zp_icache
  import icz_pkg::*;
#(
  parameter int AW          = 16,
  parameter int CACHE_BYTES = 512,
  parameter int WAYS        = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  input  logic          iq_valid,
  input  logic [AW-1:0] fetch_addr,
  output logic          fetch_valid,
  output logic [31:0]   fetch_data,
  output logic          flash_req,
  output logic [AW-1:0] flash_addr,
  input  logic [31:0]   flash_data
);

  localparam int DW    = 32;
  localparam int WORDS = CACHE_BYTES / (DW / 8);
  localparam int SETS  = WORDS / WAYS;
  localparam int IDXW  = $clog2(SETS);

  function automatic logic [IDXW-1:0] set_idx(input logic [AW-1:0] a);
    return a[IDXW-1:0];
  endfunction

  logic          lookup, pend_hit, buf_hit, any_bhit, arr_hit, arr_rd, miss;
  logic          pend_vld, buf_vld, commit;
  logic [AW-1:0] pend_addr, buf_addr;
  logic [DW-1:0] buf_data, arr_data, out_q;
  way_t          hit_way, fill_way;
  src_e          src_q;

  assign lookup   = fetch_req && !iq_valid;
  assign pend_hit = pend_vld && (pend_addr == fetch_addr);
  assign buf_hit  = buf_vld && (buf_addr == fetch_addr);
  assign any_bhit = pend_hit || buf_hit;
  assign arr_rd   = lookup && arr_hit && !any_bhit;
  assign miss     = lookup && !arr_hit && !any_bhit;

  assign flash_req  = miss;
  assign flash_addr = fetch_addr;

  icz_tag_store #(.AW(AW), .WAYS(WAYS), .SETS(SETS)) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr   (fetch_addr),
    .touch_en  (arr_rd),
    .fill_en   (commit),
    .fill_addr (buf_addr),
    .arr_hit   (arr_hit),
    .hit_way   (hit_way),
    .fill_way  (fill_way)
  );

  icz_data_array #(.WAYS(WAYS), .SETS(SETS), .DW(DW)) data_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (arr_rd),
    .rd_way  (hit_way),
    .rd_idx  (set_idx(fetch_addr)),
    .wr_en   (commit),
    .wr_way  (fill_way),
    .wr_idx  (set_idx(buf_addr)),
    .wr_data (buf_data),
    .rd_data (arr_data)
  );

  icz_wbuf #(.AW(AW), .DW(DW)) wbuf_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss       (miss),
    .miss_addr  (fetch_addr),
    .flash_data (flash_data),
    .port_free  (!arr_rd),
    .pend_vld   (pend_vld),
    .pend_addr  (pend_addr),
    .buf_vld    (buf_vld),
    .buf_addr   (buf_addr),
    .buf_data   (buf_data),
    .commit     (commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        src_q <= SRC_NONE;
    else if (!lookup)  src_q <= SRC_NONE;
    else if (any_bhit) src_q <= SRC_BUF;
    else if (arr_hit)  src_q <= SRC_ARRAY;
    else               src_q <= SRC_FLASH;
  end

  // The in-flight word is on flash_data during the cycle after its miss.
  always_ff @(posedge clk) begin
    if (lookup && any_bhit) out_q <= pend_hit ? flash_data : buf_data;
  end

  assign fetch_valid = (src_q != SRC_NONE);

  always_comb begin
    case (src_q)
      SRC_FLASH: fetch_data = flash_data;
      SRC_ARRAY: fetch_data = arr_data;
      SRC_BUF:   fetch_data = out_q;
      default:   fetch_data = '0;
    endcase
  end

  // R1
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |=> fetch_valid);

  // R5
  buf_hit_no_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup && any_bhit) |-> !flash_req);

  // R7
  iq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iq_valid |-> (!flash_req && !arr_rd));

endmodule

// File: tb/zp_icache_tb_top.sv
module zp_icache_tb_top;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_req = 1'b0;
  logic          iq_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          fetch_valid, flash_req;
  logic [31:0]   fetch_data, flash_data, flash_q;
  logic [AW-1:0] flash_addr;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  zp_icache #(.AW(AW), .CACHE_BYTES(512), .WAYS(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req),
    .iq_valid    (iq_valid),
    .fetch_addr  (fetch_addr),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .flash_req   (flash_req),
    .flash_addr  (flash_addr),
    .flash_data  (flash_data)
  );

  function automatic logic [31:0] fw(input logic [AW-1:0] a);
    return {a, ~a} ^ 32'h5A3C_96E1;
  endfunction

  // One-cycle flash model.
  always @(posedge clk) if (flash_req) flash_q <= fw(flash_addr);
  assign flash_data = flash_q;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // Lookup; checks flash strobe now and the response one cycle later (R1).
  task automatic issue(input logic [AW-1:0] a, input bit exp_flash, input string tag);
    fetch_req  = 1'b1;
    iq_valid   = 1'b0;
    fetch_addr = a;
    #1;
    chk(tag, {31'd0, flash_req}, {31'd0, exp_flash});
    if (exp_flash) chk({tag, " R2 addr"}, {16'd0, flash_addr}, {16'd0, a});
    @(negedge clk);
    chk("R1 valid", {31'd0, fetch_valid}, 32'd1);
    chk({tag, " data"}, fetch_data, fw(a));
    fetch_req = 1'b0;
  endtask

  task automatic idle(input int n);
    fetch_req = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_req = 1'b0;
    iq_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R8 reset fetch_valid", {31'd0, fetch_valid}, 32'd0);
    chk("R8 reset flash_req", {31'd0, flash_req}, 32'd0);
  endtask

  task automatic t_cold_and_inflight();
    issue(16'h0010, 1'b1, "R2 cold miss");
    issue(16'h0020, 1'b1, "R2 second miss");
    issue(16'h0020, 1'b0, "R6 in-flight hit");
    idle(3);
    issue(16'h0010, 1'b0, "R5 array hit");
    issue(16'h0020, 1'b0, "R5 array hit");
    idle(3);
  endtask

  task automatic t_buffer_hit();
    issue(16'h0030, 1'b1, "R3 miss");
    issue(16'h0010, 1'b0, "R5 hit while capturing");
    issue(16'h0030, 1'b0, "R3 buffer hit");
    issue(16'h0030, 1'b0, "R4 committed on buffer hit");
    idle(3);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 8; i++) issue(16'h0100 + 16'(i), 1'b1, "R2 stream miss");
    idle(3);
    for (int i = 0; i < 8; i++) issue(16'h0100 + 16'(i), 1'b0, "R4 stream refetch");
    idle(3);
  endtask

  task automatic t_miss_commits();
    issue(16'h00E0, 1'b1, "R4 miss E");
    issue(16'h0010, 1'b0, "R5 hit");
    issue(16'h0020, 1'b0, "R5 hit keeps buffer");
    issue(16'h00F0, 1'b1, "R4 miss F commits E");
    issue(16'h0010, 1'b0, "R5 hit");
    issue(16'h00E0, 1'b0, "R4 E resident after F");
    idle(3);
  endtask

  task automatic t_iq_block();
    fetch_req  = 1'b1;
    iq_valid   = 1'b1;
    fetch_addr = 16'h0200;
    #1;
    chk("R7 no flash while iq_valid", {31'd0, flash_req}, 32'd0);
    @(negedge clk);
    chk("R7 no response", {31'd0, fetch_valid}, 32'd0);
    iq_valid = 1'b0;
    idle(3);
    issue(16'h0200, 1'b1, "R7 not filled");
    idle(3);
  endtask

  task automatic t_plru();
    // Set 5 of 64: three tags compete for two ways.
    issue(16'h0005, 1'b1, "R9 X fill way0");   idle(3);
    issue(16'h0045, 1'b1, "R9 Y fill way1");   idle(3);
    issue(16'h0005, 1'b0, "R9 X hit");         idle(3);
    issue(16'h0085, 1'b1, "R9 Z evicts Y");    idle(3);
    issue(16'h0005, 1'b0, "R9 X kept");        idle(3);
    issue(16'h0045, 1'b1, "R9 Y was evicted"); idle(3);
    issue(16'h0005, 1'b0, "R9 X kept again");  idle(3);
    issue(16'h0085, 1'b1, "R9 Z was evicted"); idle(3);
  endtask

  task automatic t_addr_split();
    issue(16'h0410, 1'b1, "R10 tag-only alias misses");
    idle(3);
    issue(16'h0410, 1'b0, "R10 alias hit");
    issue(16'h0010, 1'b0, "R10 original kept");
    idle(3);
  endtask

  task automatic t_reset_clears();
    do_reset();
    issue(16'h0010, 1'b1, "R8 miss after reset");
    idle(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_cold_and_inflight();
    t_buffer_hit();
    t_stream();
    t_miss_commits();
    t_iq_block();
    t_plru();
    t_addr_split();
    t_reset_clears();
    done = 1'b1;
    report();
    $finish;
  end

endmodule